// File: doc/BRIEF.md
# High-Current Protection Trip-Delay Timer

This block sets how long a high-current condition must persist before a battery protection channel trips. On the CPU side there is an 8-bit register whose low six bits hold a delay code. Each code step is worth one period of a slow-domain tick, nominally 2 ms. The code reaches the slow oscillator domain through a toggle request/acknowledge handshake. While that transfer is in flight, and for a short tail after it completes, the register refuses new writes. This keeps the value on the crossing stable.

In the slow domain, a comparator-style detect input, sampled on the slow clock, starts a tick counter. When the count reaches the programmed threshold, the trip output is raised. It stays high until the FET-enable input is dropped. Protection only becomes armed after the FET enable has been high for a programmable number of slow cycles. This models the settling time of the protection circuitry.

The detect, FET-enable and tick inputs are synchronous to the slow clock. The write port is synchronous to the CPU clock.

Top module: `hc_trip_timer`

## Requirements
- R1: The read value carries the delay code in bits 5:0. Bits 7:6 always read as zero, whatever was written to them. After CPU reset the read value is 0x00.
- R2: A write made while the guard is idle loads bits 5:0 of the write data into the code. The new code is visible on the read port one CPU cycle later.
- R3: A write made while the guard is busy is dropped, and the code is left unchanged. The guard becomes busy in the cycle after an accepted write.
- R4: The guard stays busy until the slow-domain acknowledge has returned through the CPU synchronizer, and then for 3 more CPU cycles. After that, the next write is accepted.
- R5: The effective threshold is 1 for code 0 and equals the code for codes 1 to 63. While armed with detect high, trip rises on the slow edge that samples the threshold-th tick counted since detect was first sampled high. The elapsed time therefore falls between (threshold−1) and threshold tick periods.
- R6: If detect is sampled low before the trip point, the tick count returns to zero, no trip is raised, and a later detect pulse must again accumulate the full threshold.
- R7: Trip stays high while FET enable stays high, even after detect falls. It clears on the slow edge that samples FET enable low.
- R8: After FET enable rises, no tick is counted and no trip can occur until FET enable has been high for SETTLE_CYC slow cycles (default 4).
- R9: The slow domain adopts a new code only through the handshake. A setting that is accepted and then allowed to settle governs subsequent trip timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU-domain clock |
| cpu_rst_n | input | 1 | CPU-domain asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| slow_clk | input | 1 | Slow oscillator domain clock |
| slow_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| tick_i | input | 1 | One-cycle tick pulse, one per delay step |
| det_i | input | 1 | High-current detect level |
| fet_en_i | input | 1 | FET enable level; also clears trip |
| trip_o | output | 1 | Sticky trip output |

## Verification
The bench writes a second value a few cycles after a first write. A design that ignored the guard would let that value through and corrupt a setting that is still crossing domains. Trip timing is measured in ticks and in slow cycles for codes 0, 1, 2 and 0x3F. Mapping code 0 to zero ticks, or adding an off-by-one in the threshold compare, would show up as a tick count that is one wrong or as a trip that arrives instantly. Further scenarios check that an interrupted detect pulse restarts the count, that trip survives detect falling but not FET disable, and that detect already high at FET enable cannot trip inside the settling window. A design with a leaky counter or a trip that is not sticky would fail these.

// File: rtl/hct_pkg.sv
package hct_pkg;
   parameter int unsigned HCT_REG_W      = 8;
   parameter int unsigned HCT_CODE_W     = 6;
   parameter int unsigned HCT_SYNC_DEPTH = 2;
   parameter int unsigned HCT_GUARD_TAIL = 3;
   parameter int unsigned HCT_SETTLE_CYC = 4;
endpackage

// File: rtl/hct_sync.sv
module hct_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_depth
      $error("hct_sync needs at least two stages");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else if (i == 0) stg[i] <= d;
         else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/hct_cpu_reg.sv
module hct_cpu_reg #(
   parameter int unsigned REG_W      = 8,
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned GUARD_TAIL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              ack_s,
   output logic [REG_W-1:0]  rd_data,
   output logic [CODE_W-1:0] code_q,
   output logic              req_q
);
   localparam int unsigned TAIL_W = $clog2(GUARD_TAIL + 1);

   logic              pending_q;
   logic [TAIL_W-1:0] tail_q;
   logic              busy;
   logic              unused_rsv;

   assign busy       = pending_q || (tail_q != '0);
   assign unused_rsv = ^wr_data[REG_W-1:CODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q    <= '0;
         req_q     <= 1'b0;
         pending_q <= 1'b0;
         tail_q    <= '0;
      end else if (wr_en && !busy) begin
         code_q    <= wr_data[CODE_W-1:0];
         req_q     <= ~req_q;
         pending_q <= 1'b1;
      end else if (pending_q && (ack_s == req_q)) begin
         pending_q <= 1'b0;
         tail_q    <= TAIL_W'(GUARD_TAIL);
      end else if (tail_q != '0) begin
         tail_q <= tail_q - 1'b1;
      end
   end

   assign rd_data = {{(REG_W-CODE_W){1'b0}}, code_q};

   AST_WR_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> (code_q == $past(wr_data[CODE_W-1:0]))); // R2
   AST_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> $stable(code_q)); // R3
   AST_GUARD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> busy); // R3
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:CODE_W] == '0); // R1
endmodule

// File: rtl/hct_slow_cfg.sv
module hct_slow_cfg #(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_s,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_o,
   output logic              ack_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         ack_o  <= 1'b0;
      end else if (req_s != ack_o) begin
         code_o <= code_in;
         ack_o  <= req_s;
      end
   end

   AST_CFG_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_s == ack_o) |=> $stable(code_o)); // R9
endmodule

// File: rtl/hct_trip_core.sv
module hct_trip_core #(
   parameter int unsigned CODE_W     = 6,
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              det,
   input  logic              fet_en,
   input  logic [CODE_W-1:0] code,
   output logic              trip
);
   localparam int unsigned SET_W = $clog2(SETTLE_CYC + 1);

   logic [SET_W-1:0]  settle_q;
   logic              armed;
   logic [CODE_W-1:0] thr;
   logic [CODE_W-1:0] cnt_q;
   logic              hit;

   assign armed = (settle_q == SET_W'(SETTLE_CYC));
   assign thr   = (code == '0) ? CODE_W'(1) : code;
   assign hit   = armed && det && tick && (({1'b0, cnt_q} + 1'b1) == {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) settle_q <= '0;
      else if (!fet_en) settle_q <= '0;
      else if (!armed) settle_q <= settle_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (!armed || !det) cnt_q <= '0;
      else if (tick && (cnt_q < thr)) cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trip <= 1'b0;
      else if (!fet_en) trip <= 1'b0;
      else if (hit) trip <= 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= thr); // R5
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !det |=> (cnt_q == '0)); // R6
   AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && fet_en) |=> trip); // R7
   AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !fet_en |=> !trip); // R7
   AST_NO_TRIP_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fet_en) |=> !trip); // R8
endmodule

// File: rtl/hc_trip_timer.sv
module hc_trip_timer
   import hct_pkg::*;
#(
   parameter int unsigned REG_W      = HCT_REG_W,
   parameter int unsigned CODE_W     = HCT_CODE_W,
   parameter int unsigned SYNC_DEPTH = HCT_SYNC_DEPTH,
   parameter int unsigned GUARD_TAIL = HCT_GUARD_TAIL,
   parameter int unsigned SETTLE_CYC = HCT_SETTLE_CYC
) (
   input  logic             cpu_clk,
   input  logic             cpu_rst_n,
   input  logic             wr_en_i,
   input  logic [REG_W-1:0] wr_data_i,
   output logic [REG_W-1:0] rd_data_o,
   input  logic             slow_clk,
   input  logic             slow_rst_n,
   input  logic             tick_i,
   input  logic             det_i,
   input  logic             fet_en_i,
   output logic             trip_o
);
   if (REG_W <= CODE_W) begin : g_bad_width
      $error("REG_W must exceed CODE_W");
   end
   if (GUARD_TAIL < 1) begin : g_bad_tail
      $error("GUARD_TAIL must be at least 1");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   logic [CODE_W-1:0] code_cpu;
   logic [CODE_W-1:0] code_slow;
   logic              req_cpu;
   logic              req_slow;
   logic              ack_slow;
   logic              ack_cpu;

   hct_cpu_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .GUARD_TAIL(GUARD_TAIL)) u_reg (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .wr_en(wr_en_i), .wr_data(wr_data_i),
      .ack_s(ack_cpu), .rd_data(rd_data_o), .code_q(code_cpu), .req_q(req_cpu)
   );

   hct_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_req_sync (
      .clk(slow_clk), .rst_n(slow_rst_n), .d(req_cpu), .q(req_slow)
   );

   hct_slow_cfg #(.CODE_W(CODE_W)) u_cfg (
      .clk(slow_clk), .rst_n(slow_rst_n), .req_s(req_slow), .code_in(code_cpu),
      .code_o(code_slow), .ack_o(ack_slow)
   );

   hct_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ack_sync (
      .clk(cpu_clk), .rst_n(cpu_rst_n), .d(ack_slow), .q(ack_cpu)
   );

   hct_trip_core #(.CODE_W(CODE_W), .SETTLE_CYC(SETTLE_CYC)) u_core (
      .clk(slow_clk), .rst_n(slow_rst_n), .tick(tick_i), .det(det_i),
      .fet_en(fet_en_i), .code(code_slow), .trip(trip_o)
   );
endmodule

// File: tb/hc_trip_timer_tb_top.sv
`timescale 1ns/1ps
module hc_trip_timer_tb_top;
   localparam int SETTLE = 4;
   localparam int TP     = 5;

   logic       clk = 1'b0;
   logic       sclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       srst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       det = 1'b0;
   logic       fet = 1'b0;
   logic       trip;
   logic       tick;
   int         tc;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;
   always #28 sclk = ~sclk;

   always @(posedge sclk) begin
      if (!srst_n) tc <= 0;
      else tc <= (tc == TP-1) ? 0 : tc + 1;
   end
   assign tick = srst_n && (tc == TP-1);

   hc_trip_timer dut_i (
      .cpu_clk(clk), .cpu_rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .slow_clk(sclk), .slow_rst_n(srst_n), .tick_i(tick),
      .det_i(det), .fet_en_i(fet), .trip_o(trip)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // behavioural reference for the slow domain
   int m_code = 0;
   int m_cnt = 0;
   int m_settle = 0;
   bit m_trip = 1'b0;

   always @(posedge sclk) begin
      if (!srst_n) begin
         m_cnt = 0; m_settle = 0; m_trip = 1'b0;
      end else begin
         automatic int  thr   = (m_code == 0) ? 1 : m_code;
         automatic bit  armed = (m_settle >= SETTLE);
         if (!fet) m_trip = 1'b0;
         else if (armed && det && tick && (m_cnt + 1 == thr)) m_trip = 1'b1;
         if (!armed || !det) m_cnt = 0;
         else if (tick && m_cnt < thr) m_cnt++;
         if (!fet) m_settle = 0;
         else if (m_settle < SETTLE) m_settle++;
      end
   end

   always @(negedge sclk) begin
      if (srst_n && !done) check(trip == m_trip, "R5 R7 R8 cycle model trip", trip, m_trip);
   end

   task automatic cpu_write(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle_guard();
      repeat (200) @(negedge clk);
   endtask

   task automatic program_code(input int code);
      cpu_write(8'(code));
      settle_guard();
      m_code = code;
   endtask

   task automatic run_trip(input int code);
      automatic int eff = (code == 0) ? 1 : code;
      automatic int ticks = 0;
      automatic int k = 0;
      program_code(code);
      check(rd_data == 8'(code), "R9 code programmed", rd_data, code);
      @(negedge sclk); fet = 1'b1;
      repeat (SETTLE + 2) @(negedge sclk);
      check(trip == 1'b0, "R8 no trip before detect", trip, 0);
      det = 1'b1;
      while (trip !== 1'b1 && k < 2000) begin
         if (tick) ticks++;
         @(negedge sclk);
         k++;
      end
      check(ticks == eff, "R5 tick count at trip", ticks, eff);
      check((k - 1 >= (eff - 1) * TP) && (k - 1 <= eff * TP), "R5 trip window in slow cycles", k - 1, eff * TP);
      det = 1'b0;
      repeat (3) @(negedge sclk);
      check(trip == 1'b1, "R7 trip sticky after detect falls", trip, 1);
      fet = 1'b0;
      @(negedge sclk);
      check(trip == 1'b0, "R7 trip cleared by FET disable", trip, 0);
      repeat (2) @(negedge sclk);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge sclk);
      rst_n = 1'b1; srst_n = 1'b1;
      @(negedge clk);
      check(rd_data == 8'h00, "R1 reset value", rd_data, 0);
      check(trip == 1'b0, "R7 trip low after reset", trip, 0);

      // R1 R2: reserved bits masked, accepted write visible next cycle
      cpu_write(8'hFF);
      check(rd_data == 8'h3F, "R1 R2 write 0xFF reads 0x3F", rd_data, 8'h3F);
      // R3: write during guard dropped
      cpu_write(8'h05);
      check(rd_data == 8'h3F, "R3 write in guard dropped", rd_data, 8'h3F);
      cpu_write(8'h11);
      check(rd_data == 8'h3F, "R3 second write in guard dropped", rd_data, 8'h3F);
      // R4: after guard released a write is accepted
      settle_guard();
      cpu_write(8'hC5);
      check(rd_data == 8'h05, "R4 R1 write after guard accepted", rd_data, 8'h05);
      settle_guard();
      m_code = 5;

      run_trip(0);
      run_trip(1);
      run_trip(2);
      run_trip(63);

      // R6: interrupted detect restarts the count
      program_code(3);
      @(negedge sclk); fet = 1'b1;
      repeat (SETTLE + 2) @(negedge sclk);
      while (!tick) @(negedge sclk);
      det = 1'b1;
      repeat (2 * TP) @(negedge sclk);
      det = 1'b0;
      repeat (2) @(negedge sclk);
      check(trip == 1'b0, "R6 no trip after short detect", trip, 0);
      while (!tick) @(negedge sclk);
      @(negedge sclk);
      det = 1'b1;
      repeat (2 * TP) @(negedge sclk);
      check(trip == 1'b0, "R6 count restarted after gap", trip, 0);
      repeat (TP) @(negedge sclk);
      check(trip == 1'b1, "R6 trip after full threshold", trip, 1);
      det = 1'b0; fet = 1'b0;
      repeat (3) @(negedge sclk);

      // R8: detect already high when FET enabled
      program_code(0);
      det = 1'b1;
      @(negedge sclk); fet = 1'b1;
      repeat (SETTLE) begin
         @(negedge sclk);
         check(trip == 1'b0, "R8 no trip in settle window", trip, 0);
      end
      repeat (TP + 2) @(negedge sclk);
      check(trip == 1'b1, "R8 trip once armed", trip, 1);
      det = 1'b0; fet = 1'b0;
      repeat (3) @(negedge sclk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule